// File: doc/BRIEF.md
# Run-Length Update Sequencer Core

This block turns a stream of run-length-encoded update elements into a parallel output word that can change on every clock. Each element carries three things: a 4-bit operation code, a data word and a hold count. When the block takes an element, it combines the current output register with the data word using the operation. It then keeps the result on the output for the hold count plus one cycles. Each element also carries a strobe-enable bit and a pause-after bit.

The element source delivers elements on a ready/valid handshake. The core raises ready in the last cycle of the current hold, so one-cycle elements can follow each other with no idle cycles. Three inputs control progress:
- A gate input freezes the hold countdown and blocks new elements.
- A pause-after element stops the sequence after its hold. Only a retrigger pulse restarts it.
- If no element is waiting when a hold ends, a sticky underrun flag is set.

The output width and the run-length counter width are parameters, each limited to 32 or 64 bits.

Top module: `rle_seq_core`

## Requirements
- R1: When the current hold ends and an element is valid, the element is accepted in that same cycle, so hold-0 elements can be taken on consecutive clocks; `el_ready` is high after reset when gate is low.
- R2: Operation codes and the new output for current value q and data d: 0 load (d), 1 set (q|d), 2 clear (q&~d), 3 toggle (q^d), 4 shift left, 5 shift right, 6 invert (~q, d ignored), 7 AND, 8 OR, 9 XOR, 10 XNOR (~(q^d)).
- R3: Shift left and shift right move q by the value in the low log2(DATA_W) bits of d and fill with zeros.
- R4: Codes 11 to 15 are accepted as elements but leave the output unchanged.
- R5: A hold count N keeps the new value on `seq_out` for exactly N+1 cycles. `seq_out` changes only on the clock edge that accepts an element, and is visible one cycle after that edge.
- R6: `seq_strobe` is high for exactly the first cycle in which a new value is visible, and only if the element's strobe-enable bit was 1.
- R7: While `gate` is high:
  - no element is accepted;
  - the hold countdown stops;
  - no underrun is flagged.
- R8: For an element with pause-after set, the block accepts nothing once its hold ends, until a one-cycle `retrigger` pulse. The next element is then accepted in the following cycle. A retrigger outside the paused state has no effect.
- R9: `underrun` is set when a hold ends with no valid element and no pause pending. It is never set before the first element. Once set, it stays set until reset.
- R10: A synchronous reset clears `seq_out`, `seq_strobe` and `underrun` to 0.
- R11: DATA_W and CNT_W must each be 32 or 64; other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| el_valid | input | 1 | Element present on the element inputs |
| el_ready | output | 1 | Core takes the element at this edge |
| el_op | input | 4 | Operation code |
| el_data | input | DATA_W | Operand word |
| el_hold | input | CNT_W | Hold count N (value held N+1 cycles) |
| el_strobe_en | input | 1 | Emit a strobe with this element |
| el_pause | input | 1 | Pause after this element's hold |
| gate | input | 1 | Freeze streaming while high |
| retrigger | input | 1 | Leave the paused state |
| seq_out | output | DATA_W | Parallel output word |
| seq_strobe | output | 1 | One-cycle pulse on a strobed update |
| underrun | output | 1 | Sticky stream-empty flag |

## Verification
An element is accepted at one clock edge, and its result and strobe are checked at the falling edge right after it. The strobe's drop is checked one falling edge later. Hold length is measured by counting falling edges from acceptance until `underrun` rises, which is due N+2 edges after acceptance. Cycles spent gated add to that count one for one. After a retrigger pulse, the pending element's value is due two falling edges later. All inputs change on falling edges, and every check samples at a falling edge, so no check samples at the same edge where the design updates.

// File: rtl/rle_seq_pkg.sv
package rle_seq_pkg;

   typedef enum logic [3:0] {
      OP_LOAD  = 4'd0,
      OP_SET   = 4'd1,
      OP_CLR   = 4'd2,
      OP_TGL   = 4'd3,
      OP_SHL   = 4'd4,
      OP_SHR   = 4'd5,
      OP_INV   = 4'd6,
      OP_AND   = 4'd7,
      OP_OR    = 4'd8,
      OP_XOR   = 4'd9,
      OP_XNOR  = 4'd10
   } seq_op_e;

   localparam int OP_W = 4;

   function automatic bit width_ok(int w);
      return (w == 32) || (w == 64);
   endfunction

endpackage

// File: rtl/rle_seq_shift.sv
module rle_seq_shift #(
   parameter int DATA_W = 32,
   parameter bit LEFT   = 1'b1,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] stage [0:SH_W];

   assign stage[0] = din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      if (LEFT) begin : g_left
         assign stage[s+1] = amt[s] ? {stage[s][DATA_W-1-DIST:0], {DIST{1'b0}}}
                                    : stage[s];
      end else begin : g_right
         assign stage[s+1] = amt[s] ? {{DIST{1'b0}}, stage[s][DATA_W-1:DIST]}
                                    : stage[s];
      end
   end

   assign dout = stage[SH_W];

endmodule

// File: rtl/rle_seq_alu.sv
module rle_seq_alu
   import rle_seq_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] arg,
   output logic [DATA_W-1:0] res
);

   logic [DATA_W-1:0] shl_q, shr_q;

   rle_seq_shift #(.DATA_W(DATA_W), .LEFT(1'b1)) u_shl (
      .din (cur),
      .amt (arg[SH_W-1:0]),
      .dout(shl_q)
   );

   rle_seq_shift #(.DATA_W(DATA_W), .LEFT(1'b0)) u_shr (
      .din (cur),
      .amt (arg[SH_W-1:0]),
      .dout(shr_q)
   );

   always_comb begin
      case (seq_op_e'(op))
         OP_LOAD: res = arg;
         OP_SET:  res = cur | arg;
         OP_CLR:  res = cur & ~arg;
         OP_TGL:  res = cur ^ arg;
         OP_SHL:  res = shl_q;
         OP_SHR:  res = shr_q;
         OP_INV:  res = ~cur;
         OP_AND:  res = cur & arg;
         OP_OR:   res = cur | arg;
         OP_XOR:  res = cur ^ arg;
         OP_XNOR: res = ~(cur ^ arg);
         default: res = cur;   // R4: reserved codes keep the value
      endcase
   end

endmodule

// File: rtl/rle_seq_ctrl.sv
module rle_seq_ctrl #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             el_valid,
   input  logic [CNT_W-1:0] el_hold,
   input  logic             el_pause,
   input  logic             gate,
   input  logic             retrigger,
   output logic             take,
   output logic             ready,
   output logic             underrun
);

   logic             active;
   logic             paused;
   logic             pause_pend;
   logic [CNT_W-1:0] remain;
   logic             hold_last;

   assign hold_last = (remain == '0);
   assign ready     = !gate && !paused &&
                      (!active || (hold_last && !pause_pend));
   assign take      = ready && el_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         active     <= 1'b0;
         paused     <= 1'b0;
         pause_pend <= 1'b0;
         remain     <= '0;
         underrun   <= 1'b0;
      end else if (!gate) begin
         if (take) begin
            active     <= 1'b1;
            remain     <= el_hold;
            pause_pend <= el_pause;
         end else if (paused) begin
            if (retrigger) paused <= 1'b0;
         end else if (active) begin
            if (!hold_last) begin
               remain <= remain - 1'b1;
            end else begin
               active <= 1'b0;
               if (pause_pend) paused <= 1'b1;
               else            underrun <= 1'b1;
            end
         end
      end
   end

   // R9: the underrun flag never drops without reset
   a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
      underrun |=> underrun);

   // R8: a paused core stays paused until retrigger arrives
   a_r8_pause_holds: assert property (@(posedge clk) disable iff (rst)
      (paused && !retrigger) |=> paused);

   // R7: a gated cycle never ends a hold
   a_r7_gate_freezes_count: assert property (@(posedge clk) disable iff (rst)
      (gate && active) |=> (active && $stable(remain)));

endmodule

// File: rtl/rle_seq_core.sv
module rle_seq_core
   import rle_seq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              el_valid,
   output logic              el_ready,
   input  logic [3:0]        el_op,
   input  logic [DATA_W-1:0] el_data,
   input  logic [CNT_W-1:0]  el_hold,
   input  logic              el_strobe_en,
   input  logic              el_pause,
   input  logic              gate,
   input  logic              retrigger,
   output logic [DATA_W-1:0] seq_out,
   output logic              seq_strobe,
   output logic              underrun
);

   // R11: only the two supported widths elaborate
   if (!width_ok(DATA_W)) begin : g_bad_data_w
      $error("rle_seq_core: DATA_W must be 32 or 64");
   end
   if (!width_ok(CNT_W)) begin : g_bad_cnt_w
      $error("rle_seq_core: CNT_W must be 32 or 64");
   end

   logic              take;
   logic [DATA_W-1:0] next_val;

   rle_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .el_valid (el_valid),
      .el_hold  (el_hold),
      .el_pause (el_pause),
      .gate     (gate),
      .retrigger(retrigger),
      .take     (take),
      .ready    (el_ready),
      .underrun (underrun)
   );

   rle_seq_alu #(.DATA_W(DATA_W)) u_alu (
      .op (el_op),
      .cur(seq_out),
      .arg(el_data),
      .res(next_val)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         seq_out    <= '0;
         seq_strobe <= 1'b0;
      end else begin
         if (take) seq_out <= next_val;
         seq_strobe <= take && el_strobe_en;
      end
   end

   // R5: the output moves only on an accepting edge
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
      !(el_valid && el_ready) |=> $stable(seq_out));

   // R6: a strobe always follows an accepted, strobe-enabled element
   a_r6_strobe_on_accept: assert property (@(posedge clk) disable iff (rst)
      seq_strobe |-> $past(el_valid && el_ready && el_strobe_en));

   // R7: nothing is taken while the gate is high
   a_r7_gate_no_take: assert property (@(posedge clk) disable iff (rst)
      gate |-> !el_ready);

endmodule

// File: tb/rle_seq_core_tb_top.sv
module rle_seq_core_tb_top;

   localparam int DW = 32;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          el_valid = 1'b0;
   logic          el_ready;
   logic [3:0]    el_op = '0;
   logic [DW-1:0] el_data = '0;
   logic [CW-1:0] el_hold = '0;
   logic          el_strobe_en = 1'b0;
   logic          el_pause = 1'b0;
   logic          gate = 1'b0;
   logic          retrigger = 1'b0;
   logic [DW-1:0] seq_out;
   logic          seq_strobe;
   logic          underrun;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   rle_seq_core #(.DATA_W(DW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst(rst), .el_valid(el_valid), .el_ready(el_ready),
      .el_op(el_op), .el_data(el_data), .el_hold(el_hold),
      .el_strobe_en(el_strobe_en), .el_pause(el_pause), .gate(gate),
      .retrigger(retrigger), .seq_out(seq_out), .seq_strobe(seq_strobe),
      .underrun(underrun)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] q,
                                           input logic [DW-1:0] d);
      case (op)
         0:  return d;
         1:  return q | d;
         2:  return q & ~d;
         3:  return q ^ d;
         4:  return q << d[4:0];
         5:  return q >> d[4:0];
         6:  return ~q;
         7:  return q & d;
         8:  return q | d;
         9:  return q ^ d;
         10: return ~(q ^ d);
         default: return q;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; el_valid = 1'b0; gate = 1'b0; retrigger = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic push(input int op, input logic [DW-1:0] d, input int hold,
                       input bit stb, input bit pse, output int waited);
      el_op = op[3:0]; el_data = d; el_hold = hold; el_strobe_en = stb;
      el_pause = pse; el_valid = 1'b1;
      waited = 0;
      #1;
      while (!el_ready) begin
         @(negedge clk); #1; waited++;
      end
      @(posedge clk);
      @(negedge clk);
      el_valid = 1'b0;
   endtask

   task automatic cycles_to_underrun(output int n);
      n = 0;
      while (!underrun && n < 100) begin
         @(negedge clk); n++;
      end
   endtask

   initial begin
      logic [DW-1:0] pats [4];
      logic [DW-1:0] seeds [3];
      int w, n;
      bit no_wait;
      pats[0] = 32'h0000_0005; pats[1] = 32'hF0F0_1234;
      pats[2] = 32'h8000_001F; pats[3] = 32'hFFFF_FFE1;
      seeds[0] = 32'hA5A5_5A5A; seeds[1] = 32'h0000_0001; seeds[2] = 32'hDEAD_BEEF;

      do_reset();
      #1;
      chk(seq_out == 0, "R10 reset out", seq_out, 0);
      chk(seq_strobe == 0, "R10 reset strobe", seq_strobe, 0);
      chk(underrun == 0, "R10 reset underrun", underrun, 0);
      chk(el_ready == 1, "R1 ready after reset", el_ready, 1);
      repeat (10) @(negedge clk);
      chk(underrun == 0, "R9 no underrun before first element", underrun, 0);

      // R2 R3 R4: every code with several operands, back to back
      for (int op = 0; op < 16; op++) begin
         for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 4; p++) begin
               push(0, seeds[s], 0, 1'b0, 1'b0, w);
               push(op, pats[p], 0, 1'b0, 1'b0, w);
               chk(seq_out == model(op, seeds[s], pats[p]),
                   (op >= 11) ? "R4 reserved code" :
                   (op == 4 || op == 5) ? "R3 shift" : "R2 operation",
                   seq_out, model(op, seeds[s], pats[p]));
            end
         end
      end

      // R1: a run of hold-0 elements never waits and changes every cycle
      do_reset();
      no_wait = 1'b1;
      for (int i = 0; i < 20; i++) begin
         push(3, 32'h1 << i, 0, 1'b0, 1'b0, w);
         if (w != 0) no_wait = 1'b0;
         chk(seq_out == ((32'h1 << (i + 1)) - 1), "R1 one element per clock",
             seq_out, (32'h1 << (i + 1)) - 1);
      end
      chk(no_wait, "R1 zero wait states", no_wait, 1);

      // R5 R9: hold length measured by underrun timing
      for (int h = 0; h < 6; h++) begin
         do_reset();
         push(0, 32'h77 + h, h, 1'b0, 1'b0, w);
         cycles_to_underrun(n);
         chk(n == h + 1, "R5 hold N lasts N+1 cycles", n, h + 1);
         chk(seq_out == 32'h77 + h, "R5 value kept through hold", seq_out, 32'h77 + h);
      end
      push(0, 32'h1, 0, 1'b0, 1'b0, w);
      chk(underrun == 1, "R9 underrun sticky", underrun, 1);

      // R6: strobe per element, single cycle
      do_reset();
      push(0, 32'h55, 2, 1'b1, 1'b0, w);
      chk(seq_strobe == 1, "R6 strobe on first cycle", seq_strobe, 1);
      @(negedge clk);
      chk(seq_strobe == 0, "R6 strobe one cycle only", seq_strobe, 0);
      @(negedge clk);
      push(1, 32'h100, 0, 1'b0, 1'b0, w);
      chk(seq_strobe == 0 && seq_out == 32'h155, "R6 update without strobe",
          {seq_strobe, seq_out}, {1'b0, 32'h155});

      // R7: gate stretches the hold
      do_reset();
      push(0, 32'h9, 2, 1'b0, 1'b0, w);
      gate = 1'b1;
      n = 0;
      while (!underrun && n < 50) begin
         @(negedge clk); n++;
         if (n == 3) gate = 1'b0;
      end
      chk(n == 6, "R7 gate freezes countdown", n, 6);

      // R7: pending element held off while gated, no underrun
      do_reset();
      push(0, 32'hC3, 0, 1'b0, 1'b0, w);
      gate = 1'b1;
      el_op = 4'd3; el_data = 32'hFF; el_hold = 0; el_valid = 1'b1;
      repeat (5) @(negedge clk);
      chk(seq_out == 32'hC3, "R7 no element taken while gated", seq_out, 32'hC3);
      chk(underrun == 0, "R7 no underrun while gated", underrun, 0);
      gate = 1'b0;
      @(negedge clk);
      el_valid = 1'b0;
      chk(seq_out == 32'h3C, "R7 element taken after gate drops", seq_out, 32'h3C);

      // R8: pause then retrigger
      do_reset();
      push(0, 32'hA, 1, 1'b0, 1'b1, w);
      el_op = 4'd0; el_data = 32'hB; el_hold = 0; el_pause = 1'b0; el_valid = 1'b1;
      repeat (6) @(negedge clk);
      chk(seq_out == 32'hA, "R8 paused core takes nothing", seq_out, 32'hA);
      chk(underrun == 0, "R8 no underrun while paused", underrun, 0);
      retrigger = 1'b1;
      @(negedge clk);
      retrigger = 1'b0;
      chk(seq_out == 32'hA, "R8 still held at retrigger edge", seq_out, 32'hA);
      @(negedge clk);
      el_valid = 1'b0;
      chk(seq_out == 32'hB, "R8 next element after retrigger", seq_out, 32'hB);

      // R8: retrigger outside pause has no effect on the hold
      do_reset();
      push(0, 32'h3, 3, 1'b0, 1'b0, w);
      retrigger = 1'b1;
      cycles_to_underrun(n);
      retrigger = 1'b0;
      chk(n == 4, "R8 retrigger ignored when running", n, 4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule